// File: doc/BRIEF.md
# Control-Word Driven Register Datapath

This block is the execution half of a small processor core. Seven general registers sit around one arithmetic and logic unit. Two read multiplexers place operands on an A bus and a B bus, and a write decoder picks the register that takes the result. A 14-bit control word drives all of this, one word per clock. An external sequencer produces the words, and that sequencer lies outside this block.

In each cycle the word chooses the two operand sources, the operation, and an optional destination. The result is captured in an output register on every rising edge. When a destination is named, the same edge also writes the result into that general register. Operand reads are combinational. A register can therefore be read and rewritten in one cycle, and it supplies its old value.

The data width is a parameter with a default of 8 bits. An operation code outside the defined set gives a zero result. It also raises an illegal-operation flag and blocks the register write.

Top module: `cwd_datapath`

## Requirements
- R1: The control word holds four fields. Bits 13:11 select the A source, bits 10:8 select the B source, bits 7:5 select the destination and bits 4:0 hold the operation code.
- R2: On each read bus, source code 0 selects the external input and codes 1 to 7 select registers 1 to 7. The A and B selections are independent of each other.
- R3: Destination code 0 writes no register, whatever result the ALU produces.
- R4: Destination code n (1 to 7) loads register n with the result on the rising edge. When a register is both source and destination, the operation uses its value from before the edge.
- R5: Reset (active low) clears all seven registers and the output register, and deasserts the illegal flag.
- R6: The arithmetic operations wrap modulo 2^width. They are pass A = 00000, A+1 = 00001, A+B = 00010, A−B = 00101 and A−1 = 00110.
- R7: The bitwise operations are AND = 01000, OR = 01010, XOR = 01100 and NOT A = 01110.
- R8: Code 10000 shifts A right by one and fills the top bit with 0. Code 11000 shifts A left by one and fills the bottom bit with 0.
- R9: Any other operation code puts 0 in the output register, sets the illegal flag for that cycle and writes no register.
- R10: The output register and the illegal flag update on every rising edge from the word applied before that edge, whether or not a destination is selected. They hold their values between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_word | input | 14 | Control word for this cycle |
| ext_in | input | DATA_W | External operand, reached with source code 0 |
| dp_out | output | DATA_W | Registered ALU result |
| op_illegal | output | 1 | Registered flag for an undefined operation code |

## Verification
Register contents are not visible at the ports. The case that takes the most care is showing that something did not happen: that a cycle with destination code 0, or with an undefined operation code, left every register unchanged. The stimulus first loads a distinct value into each register from the external input. After each suspect cycle it reads every register back with a pass-A word that writes nothing, and compares the results with a shadow copy. Read-modify-write in a single cycle is exercised by applying a doubling word to the same register several times in a row.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
   localparam int SEL_W   = 3;
   localparam int OPR_W   = 5;
   localparam int CW_W    = 3 * SEL_W + OPR_W;
   localparam int NUM_GPR = (1 << SEL_W) - 1;

   typedef enum logic [OPR_W-1:0] {
      OP_TSFA = 5'b00000,
      OP_INCA = 5'b00001,
      OP_ADD  = 5'b00010,
      OP_SUB  = 5'b00101,
      OP_DECA = 5'b00110,
      OP_AND  = 5'b01000,
      OP_OR   = 5'b01010,
      OP_XOR  = 5'b01100,
      OP_COMA = 5'b01110,
      OP_SHRA = 5'b10000,
      OP_SHLA = 5'b11000
   } alu_op_e;

   typedef struct packed {
      logic [SEL_W-1:0] src_a;
      logic [SEL_W-1:0] src_b;
      logic [SEL_W-1:0] dest;
      logic [OPR_W-1:0] opr;
   } ctrl_word_t;
endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
   import cwd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  rd_a_sel,
   input  logic [SEL_W-1:0]  rd_b_sel,
   input  logic [DATA_W-1:0] ext_in,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] a_bus,
   output logic [DATA_W-1:0] b_bus
);
   logic [NUM_GPR-1:0][DATA_W-1:0] regs_q;
   logic [NUM_GPR-1:0]             load_vec;

   for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
      assign load_vec[g] = wr_en && (wr_sel == SEL_W'(g + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           regs_q[g] <= '0;
         else if (load_vec[g]) regs_q[g] <= wr_data;
      end

      a_r4_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
         load_vec[g] |=> regs_q[g] == $past(wr_data));
   end

   always_comb begin
      a_bus = ext_in;
      b_bus = ext_in;
      for (int i = 0; i < NUM_GPR; i++) begin
         if (rd_a_sel == SEL_W'(i + 1)) a_bus = regs_q[i];
         if (rd_b_sel == SEL_W'(i + 1)) b_bus = regs_q[i];
      end
   end

   a_r4_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_vec));

   a_r3_no_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel == '0) |=> $stable(regs_q));
endmodule

// File: rtl/cwd_alu.sv
module cwd_alu
   import cwd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OPR_W-1:0]  opr,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [DATA_W-1:0] result,
   output logic              illegal
);
   always_comb begin
      illegal = 1'b0;
      case (opr)
         OP_TSFA: result = op_a;
         OP_INCA: result = op_a + DATA_W'(1);
         OP_ADD:  result = op_a + op_b;
         OP_SUB:  result = op_a - op_b;
         OP_DECA: result = op_a - DATA_W'(1);
         OP_AND:  result = op_a & op_b;
         OP_OR:   result = op_a | op_b;
         OP_XOR:  result = op_a ^ op_b;
         OP_COMA: result = ~op_a;
         OP_SHRA: result = {1'b0, op_a[DATA_W-1:1]};
         OP_SHLA: result = {op_a[DATA_W-2:0], 1'b0};
         default: begin
            result  = '0;
            illegal = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/cwd_datapath.sv
module cwd_datapath
   import cwd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [13:0]       ctrl_word,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] dp_out,
   output logic              op_illegal
);
   if (DATA_W < 2) begin : g_bad_width
      $error("cwd_datapath: DATA_W must be at least 2");
   end
   if (CW_W != 14) begin : g_bad_cw
      $error("cwd_datapath: control word layout must total 14 bits");
   end

   ctrl_word_t        cw;
   logic [DATA_W-1:0] a_bus, b_bus, alu_res;
   logic              alu_bad;

   assign cw = ctrl_word_t'(ctrl_word);

   cwd_regfile #(.DATA_W(DATA_W)) regfile_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_sel (cw.src_a),
      .rd_b_sel (cw.src_b),
      .ext_in   (ext_in),
      .wr_sel   (cw.dest),
      .wr_en    (!alu_bad),
      .wr_data  (alu_res),
      .a_bus    (a_bus),
      .b_bus    (b_bus)
   );

   cwd_alu #(.DATA_W(DATA_W)) alu_i (
      .opr     (cw.opr),
      .op_a    (a_bus),
      .op_b    (b_bus),
      .result  (alu_res),
      .illegal (alu_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_out     <= '0;
         op_illegal <= 1'b0;
      end else begin
         dp_out     <= alu_res;
         op_illegal <= alu_bad;
      end
   end

   a_r2_ext_on_a: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.src_a == '0) |-> a_bus == ext_in);

   a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
      op_illegal |-> dp_out == '0);

   a_r6_add_result: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.opr == OP_ADD) |=> dp_out == $past(DATA_W'(a_bus + b_bus)));

   a_r10_out_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (cw.opr == OP_TSFA) |=> dp_out == $past(a_bus));
endmodule

// File: tb/cwd_datapath_tb_top.sv
`timescale 1ns/1ps
module cwd_datapath_tb_top;
   localparam int W = 8;
   localparam logic [4:0] TSFA = 5'b00000, INCA = 5'b00001, ADD = 5'b00010,
      SUB = 5'b00101, DECA = 5'b00110, ANDO = 5'b01000, ORO = 5'b01010,
      XORO = 5'b01100, COMA = 5'b01110, SHRA = 5'b10000, SHLA = 5'b11000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [13:0]  ctrl_word = '0;
   logic [W-1:0] ext_in = '0;
   logic [W-1:0] dp_out;
   logic         op_illegal;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [W-1:0] m [1:7];

   always #2 clk = ~clk;

   cwd_datapath #(.DATA_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
      .ext_in(ext_in), .dp_out(dp_out), .op_illegal(op_illegal)
   );

   function automatic logic [13:0] mk(input int a, input int b, input int d, input logic [4:0] op);
      return {3'(a), 3'(b), 3'(d), op};
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [13:0] w, input logic [W-1:0] x);
      @(negedge clk);
      ctrl_word = w;
      ext_in    = x;
      @(posedge clk);
      #1;
   endtask

   task automatic load(input int n, input logic [W-1:0] v);
      drive(mk(0, 0, n, TSFA), v);
      chk("R4 load output", dp_out, v);
      m[n] = v;
   endtask

   task automatic peek_all(input string tag);
      for (int n = 1; n <= 7; n++) begin
         drive(mk(n, 0, 0, TSFA), 8'h00);
         chk(tag, dp_out, m[n]);
      end
   endtask

   task automatic t_reset;
      chk("R5 out after reset", dp_out, '0);
      chk("R5 illegal after reset", W'(op_illegal), '0);
      for (int n = 1; n <= 7; n++) m[n] = '0;
      peek_all("R5 register after reset");
   endtask

   task automatic t_load;
      for (int n = 1; n <= 7; n++) load(n, W'(8'h11 * n));
      peek_all("R4 R2 register readback");
   endtask

   task automatic t_examples;
      load(2, 8'h50); load(3, 8'h13); load(4, 8'h0C); load(5, 8'h30); load(6, 8'hFF);
      drive(14'b010_011_001_00101, 8'h00);
      chk("R1 R6 R1=R2-R3 output", dp_out, 8'h3D); m[1] = 8'h3D;
      drive(14'b100_101_100_01010, 8'h00);
      chk("R1 R7 R4=R4|R5 output", dp_out, 8'h3C); m[4] = 8'h3C;
      drive(14'b110_000_110_00001, 8'h00);
      chk("R1 R6 R6=R6+1 wrap", dp_out, 8'h00); m[6] = 8'h00;
      peek_all("R1 R4 example readback");
   endtask

   task automatic t_ops;
      logic [4:0] ops [11] = '{TSFA, INCA, ADD, SUB, DECA, ANDO, ORO, XORO, COMA, SHRA, SHLA};
      logic [W-1:0] ex [11] = '{8'hA5, 8'hA6, 8'hE1, 8'h69, 8'hA4, 8'h24, 8'hBD, 8'h99, 8'h5A, 8'h52, 8'h4A};
      load(7, 8'h3C);
      for (int i = 0; i < 11; i++) begin
         drive(mk(0, 7, 0, ops[i]), 8'hA5);
         chk(i < 5 ? "R6 arith op" : (i < 9 ? "R7 logic op" : "R8 shift op"), dp_out, ex[i]);
      end
      drive(mk(0, 7, 0, DECA), 8'h00); chk("R6 decrement wrap", dp_out, 8'hFF);
      drive(mk(0, 7, 0, SUB), 8'h00);  chk("R6 subtract borrow", dp_out, 8'hC4);
      drive(mk(0, 0, 0, ADD), 8'h21);  chk("R2 both buses external", dp_out, 8'h42);
      drive(mk(7, 0, 0, SUB), 8'h0C);  chk("R2 register on A ext on B", dp_out, 8'h30);
      drive(mk(0, 0, 0, SHRA), 8'h81); chk("R8 right shift zero fill", dp_out, 8'h40);
      drive(mk(0, 0, 0, SHLA), 8'h81); chk("R8 left shift zero fill", dp_out, 8'h02);
   endtask

   task automatic t_same_reg;
      drive(mk(3, 3, 3, ADD), 8'h00); chk("R4 self add first", dp_out, 8'h26);
      drive(mk(3, 3, 3, ADD), 8'h00); chk("R4 self add second", dp_out, 8'h4C);
      m[3] = 8'h4C;
      drive(mk(3, 0, 0, TSFA), 8'h00); chk("R4 self add readback", dp_out, 8'h4C);
   endtask

   task automatic t_no_dest;
      drive(mk(7, 7, 0, ADD), 8'h00);  chk("R3 no-dest output", dp_out, 8'h78);
      drive(mk(0, 0, 0, COMA), 8'h00); chk("R3 no-dest output", dp_out, 8'hFF);
      peek_all("R3 registers unchanged");
   endtask

   task automatic t_illegal;
      logic [4:0] bad [4] = '{5'b00011, 5'b11111, 5'b10001, 5'b00100};
      for (int i = 0; i < 4; i++) begin
         drive(mk(0, 0, 1, bad[i]), 8'h77);
         chk("R9 illegal zero result", dp_out, 8'h00);
         chk("R9 illegal flag set", W'(op_illegal), 8'h01);
      end
      peek_all("R9 no write on illegal");
      chk("R9 flag clears on legal op", W'(op_illegal), 8'h00);
   endtask

   task automatic t_timing;
      drive(mk(0, 0, 0, TSFA), 8'h5A);
      chk("R10 output after edge", dp_out, 8'h5A);
      @(negedge clk);
      ctrl_word = mk(0, 0, 0, TSFA);
      ext_in    = 8'hC3;
      #1;
      chk("R10 output holds before edge", dp_out, 8'h5A);
      @(posedge clk);
      #1;
      chk("R10 output takes new value", dp_out, 8'hC3);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_load();
      t_examples();
      t_ops();
      t_same_reg();
      t_no_dest();
      t_illegal();
      t_timing();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule